// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Bank

This block holds eight single-bit ownership tokens that two independent ports, called left and right, use to agree on which of them may touch a shared resource. Each port reaches the bank with a memory-style cycle. The semaphore strobe is low while the ordinary memory chip enable is high. The low address bits pick a token and bit 0 of the write data says whether the port wants the token or gives it back. Writing 0 asks for a token and writing 1 hands it back.

A read shows the port its own view of the token. It reads 0 when it holds the token and 1 when it does not. A request against a token held by the other side is remembered. The token then moves to the waiting side as soon as the holder gives it back. If both sides ask for a free token in the same cycle, the left side gets it and the right request waits. All state sits in clocked registers with an active-low asynchronous reset. Read data is a combinational view of that state.

Top module: `sem_token_bank`

## Requirements
- R1: After reset every token is free: a semaphore read of any of the 8 tokens from either port returns all ones.
- R2: A port makes a semaphore access only when its semaphore strobe is low and its memory chip enable is high. With the chip enable low, a write leaves every token unchanged and a read returns all zeros.
- R3: Address bits [2:0] select the token. Every higher address bit is ignored.
- R4: On a semaphore write only data bit 0 counts: 0 requests the token and 1 releases it. All other data bits are ignored.
- R5: A request to a free token is granted at the next rising clock edge. From then on the requesting port reads 0 and the other port reads 1.
- R6: A request to a token held by the other port leaves the requester reading 1 and is kept pending. When the holder releases, the token passes to the requester at that same edge, and the requester reads 0.
- R7: When both ports request the same free token in the same cycle, the left port gets it and the right request is kept pending.
- R8: A release by the holder with no pending request from the other side makes the token free. Either port can then take it.
- R9: A semaphore read is done with write enable high and output enable low. It returns the port's view of the token copied onto all data bits. With output enable high the data output is all zeros.
- R10: No token is ever held by both ports, and a held token stays with its holder until the holder releases it.
- R11: A release written by a port that does not hold the token withdraws that port's pending request and has no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l_ce_ni | input | 1 | Left memory chip enable, active low (must be high for semaphore access) |
| l_sem_ni | input | 1 | Left semaphore strobe, active low |
| l_we_ni | input | 1 | Left write enable, active low |
| l_oe_ni | input | 1 | Left output enable, active low |
| l_addr_i | input | 12 | Left address; bits [2:0] select the token |
| l_wdata_i | input | 16 | Left write data; bit 0 is request (0) or release (1) |
| l_rdata_o | output | 16 | Left read data |
| r_ce_ni | input | 1 | Right memory chip enable, active low |
| r_sem_ni | input | 1 | Right semaphore strobe, active low |
| r_we_ni | input | 1 | Right write enable, active low |
| r_oe_ni | input | 1 | Right output enable, active low |
| r_addr_i | input | 12 | Right address; bits [2:0] select the token |
| r_wdata_i | input | 16 | Right write data; bit 0 is request (0) or release (1) |
| r_rdata_o | output | 16 | Right read data |

## Verification
A semaphore write changes token state at the first rising edge at which it is presented. The read path has no register, so a read shows the new state in the cycle right after that edge. The bench drives each write just after a falling edge and holds it across one rising edge. It then returns the port to idle at the next falling edge. Reads are set up in the low half of a clock cycle and sampled a couple of nanoseconds later, before the next rising edge. Each check therefore sees exactly the state left by the writes before it.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [1:0] {
    TOK_FREE  = 2'd0,
    TOK_LEFT  = 2'd1,
    TOK_RIGHT = 2'd2
  } tok_owner_e;
endpackage

// File: rtl/sem_token_cell.sv
module sem_token_cell
  import sem_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_l_i,
  input  logic rel_l_i,
  input  logic req_r_i,
  input  logic rel_r_i,
  output logic own_l_o,
  output logic own_r_o
);
  tok_owner_e own_q, own_d;
  logic       pend_l_q, pend_l_d;
  logic       pend_r_q, pend_r_d;

  always_comb begin
    own_d    = own_q;
    pend_l_d = pend_l_q;
    pend_r_d = pend_r_q;
    unique case (own_q)
      TOK_FREE: begin
        pend_l_d = 1'b0;
        pend_r_d = 1'b0;
        if (req_l_i) begin
          own_d    = TOK_LEFT;
          pend_r_d = req_r_i;  // tie: left wins, right waits
        end else if (req_r_i) begin
          own_d = TOK_RIGHT;
        end
      end
      TOK_LEFT: begin
        pend_l_d = 1'b0;
        if (rel_l_i) begin
          if ((pend_r_q && !rel_r_i) || req_r_i) begin
            own_d    = TOK_RIGHT;
            pend_r_d = 1'b0;
          end else begin
            own_d    = TOK_FREE;
            pend_r_d = 1'b0;
          end
        end else if (req_r_i) begin
          pend_r_d = 1'b1;
        end else if (rel_r_i) begin
          pend_r_d = 1'b0;
        end
      end
      TOK_RIGHT: begin
        pend_r_d = 1'b0;
        if (rel_r_i) begin
          if ((pend_l_q && !rel_l_i) || req_l_i) begin
            own_d    = TOK_LEFT;
            pend_l_d = 1'b0;
          end else begin
            own_d    = TOK_FREE;
            pend_l_d = 1'b0;
          end
        end else if (req_l_i) begin
          pend_l_d = 1'b1;
        end else if (rel_l_i) begin
          pend_l_d = 1'b0;
        end
      end
      default: begin
        own_d    = TOK_FREE;
        pend_l_d = 1'b0;
        pend_r_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_q    <= TOK_FREE;
      pend_l_q <= 1'b0;
      pend_r_q <= 1'b0;
    end else begin
      own_q    <= own_d;
      pend_l_q <= pend_l_d;
      pend_r_q <= pend_r_d;
    end
  end

  assign own_l_o = (own_q == TOK_LEFT);
  assign own_r_o = (own_q == TOK_RIGHT);

  p_take_free_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_q == TOK_FREE && !req_l_i && req_r_i) |=> own_r_o);
  p_tie_left_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_q == TOK_FREE && req_l_i && req_r_i) |=> (own_l_o && pend_r_q));
  p_handoff_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_l_o && rel_l_i && pend_r_q && !rel_r_i) |=> own_r_o);
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_l_o && !rel_l_i) |=> own_l_o);
  p_hold_right_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_r_o && !rel_r_i) |=> own_r_o);
  p_free_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_l_o && rel_l_i && !pend_r_q && !req_r_i) |=> (own_q == TOK_FREE));
  p_withdraw_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_l_o && rel_r_i && !rel_l_i) |=> !pend_r_q);
endmodule

// File: rtl/sem_port_if.sv
module sem_port_if #(
  parameter int N_SEM  = 8,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  localparam int SEL_W = $clog2(N_SEM)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              sem_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N_SEM-1:0]  own_i,
  output logic [N_SEM-1:0]  req_o,
  output logic [N_SEM-1:0]  rel_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic             acc, wr, rd;
  logic [SEL_W-1:0] sel;

  assign acc = !sem_ni && ce_ni;
  assign wr  = acc && !we_ni;
  assign rd  = acc && we_ni && !oe_ni;
  assign sel = addr_i[SEL_W-1:0];

  for (genvar i = 0; i < N_SEM; i++) begin : g_dec
    assign req_o[i] = wr && (sel == SEL_W'(i)) && !wdata_i[0];
    assign rel_o[i] = wr && (sel == SEL_W'(i)) &&  wdata_i[0];
  end

  assign rdata_o = rd ? {DATA_W{!own_i[sel]}} : '0;

  p_one_op_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({req_o, rel_o}));
  p_ce_block_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_ni |-> (req_o == '0 && rel_o == '0 && rdata_o == '0));
  p_replicate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o == '0 || rdata_o == '1));
endmodule

// File: rtl/sem_token_bank.sv
module sem_token_bank #(
  parameter int N_SEM  = 8,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l_ce_ni,
  input  logic              l_sem_ni,
  input  logic              l_we_ni,
  input  logic              l_oe_ni,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic [DATA_W-1:0] l_wdata_i,
  output logic [DATA_W-1:0] l_rdata_o,
  input  logic              r_ce_ni,
  input  logic              r_sem_ni,
  input  logic              r_we_ni,
  input  logic              r_oe_ni,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic [DATA_W-1:0] r_wdata_i,
  output logic [DATA_W-1:0] r_rdata_o
);
  logic [N_SEM-1:0] req_l, rel_l, req_r, rel_r;
  logic [N_SEM-1:0] own_l, own_r;

  sem_port_if #(.N_SEM(N_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_left (
    .clk_i, .rst_ni,
    .ce_ni(l_ce_ni), .sem_ni(l_sem_ni), .we_ni(l_we_ni), .oe_ni(l_oe_ni),
    .addr_i(l_addr_i), .wdata_i(l_wdata_i), .own_i(own_l),
    .req_o(req_l), .rel_o(rel_l), .rdata_o(l_rdata_o)
  );

  sem_port_if #(.N_SEM(N_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_right (
    .clk_i, .rst_ni,
    .ce_ni(r_ce_ni), .sem_ni(r_sem_ni), .we_ni(r_we_ni), .oe_ni(r_oe_ni),
    .addr_i(r_addr_i), .wdata_i(r_wdata_i), .own_i(own_r),
    .req_o(req_r), .rel_o(rel_r), .rdata_o(r_rdata_o)
  );

  for (genvar i = 0; i < N_SEM; i++) begin : g_tok
    sem_token_cell u_cell (
      .clk_i, .rst_ni,
      .req_l_i(req_l[i]), .rel_l_i(rel_l[i]),
      .req_r_i(req_r[i]), .rel_r_i(rel_r[i]),
      .own_l_o(own_l[i]), .own_r_o(own_r[i])
    );
  end

  p_mutex_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_l & own_r) == '0);
endmodule

// File: tb/sem_token_bank_tb.sv
module sem_token_bank_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic l_ce_ni, l_sem_ni, l_we_ni, l_oe_ni;
  logic r_ce_ni, r_sem_ni, r_we_ni, r_oe_ni;
  logic [11:0] l_addr, r_addr;
  logic [15:0] l_wdata, r_wdata, l_rdata, r_rdata;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sem_token_bank u_dut (
    .clk_i(clk), .rst_ni,
    .l_ce_ni, .l_sem_ni, .l_we_ni, .l_oe_ni, .l_addr_i(l_addr),
    .l_wdata_i(l_wdata), .l_rdata_o(l_rdata),
    .r_ce_ni, .r_sem_ni, .r_we_ni, .r_oe_ni, .r_addr_i(r_addr),
    .r_wdata_i(r_wdata), .r_rdata_o(r_rdata)
  );

  task automatic idle();
    l_ce_ni = 1; l_sem_ni = 1; l_we_ni = 1; l_oe_ni = 1; l_addr = '0; l_wdata = '0;
    r_ce_ni = 1; r_sem_ni = 1; r_we_ni = 1; r_oe_ni = 1; r_addr = '0; r_wdata = '0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  // right=0 left port, right=1 right port; drive a write for one edge
  task automatic put(input bit right, input logic [11:0] a, input logic [15:0] d);
    if (!right) begin l_sem_ni = 0; l_we_ni = 0; l_addr = a; l_wdata = d; end
    else        begin r_sem_ni = 0; r_we_ni = 0; r_addr = a; r_wdata = d; end
  endtask

  task automatic expect_rd(input bit right, input logic [11:0] a, input logic [15:0] exp,
                           input string tag, input bit oe_n = 0, input bit ce_n = 1);
    logic [15:0] got;
    if (!right) begin l_ce_ni = ce_n; l_sem_ni = 0; l_we_ni = 1; l_oe_ni = oe_n; l_addr = a; end
    else        begin r_ce_ni = ce_n; r_sem_ni = 0; r_we_ni = 1; r_oe_ni = oe_n; r_addr = a; end
    #2;
    got = right ? r_rdata : l_rdata;
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s side=%0d addr=%h actual=%h expected=%h", tag, right, a, got, exp);
    end
    idle();
    #1;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1: all tokens free after reset
    for (int i = 0; i < 8; i++) begin
      expect_rd(0, 12'(i), 16'hFFFF, "R1");
      expect_rd(1, 12'(i), 16'hFFFF, "R1");
    end

    // R5, R3, R4, R8: each side takes and returns each token, junk in upper bits
    for (int s = 0; s < 2; s++) begin
      for (int i = 0; i < 8; i++) begin
        logic [11:0] a;
        a = {9'(12'h1A5 + 37 * i), 3'(i)};
        put(s[0], a, 16'hFFFE);
        step();
        expect_rd(s[0], 12'(i) | 12'h8F0, 16'h0000, "R5_own");
        expect_rd(!s[0], {9'(i * 11), 3'(i)}, 16'hFFFF, "R5_other");
        expect_rd(!s[0], 12'((i + 1) % 8), 16'hFFFF, "R3_neighbour");
        put(s[0], a ^ 12'hE08, 16'h0001);
        step();
        expect_rd(s[0], 12'(i), 16'hFFFF, "R8_self");
        expect_rd(!s[0], 12'(i), 16'hFFFF, "R8_other");
      end
    end

    // R4: request with bit0 clear but other bits set; release with other bits clear
    put(0, 12'd2, 16'h5554);
    step();
    expect_rd(0, 12'd2, 16'h0000, "R4_req");
    put(0, 12'd2, 16'hAAAB);
    step();
    expect_rd(0, 12'd2, 16'hFFFF, "R4_rel");

    // R2: chip enable low blocks semaphore access
    l_ce_ni = 0; put(0, 12'd4, 16'h0000);
    step();
    expect_rd(0, 12'd4, 16'hFFFF, "R2_nowrite");
    expect_rd(1, 12'd4, 16'hFFFF, "R2_nowrite");
    expect_rd(0, 12'd4, 16'h0000, "R2_ceread", 1'b0, 1'b0);

    // R9: output enable high gives zero data; replication under ownership
    put(1, 12'd1, 16'h0000);
    step();
    expect_rd(1, 12'd1, 16'h0000, "R9_oe", 1'b1);
    expect_rd(0, 12'd1, 16'h0000, "R9_oe", 1'b1);
    expect_rd(0, 12'd1, 16'hFFFF, "R9_rep");
    put(1, 12'd1, 16'h0001);
    step();

    // R6: pending request hands over on release
    put(0, 12'd3, 16'h0000);
    step();
    put(1, 12'd3, 16'h0000);
    step();
    expect_rd(1, 12'd3, 16'hFFFF, "R6_wait");
    expect_rd(0, 12'd3, 16'h0000, "R10_keep");
    put(0, 12'd3, 16'h0001);
    step();
    expect_rd(1, 12'd3, 16'h0000, "R6_pass");
    expect_rd(0, 12'd3, 16'hFFFF, "R6_pass");
    put(1, 12'd3, 16'h0001);
    step();
    expect_rd(0, 12'd3, 16'hFFFF, "R8_free");

    // R11: withdraw pending, then holder release leaves token free
    put(1, 12'd5, 16'h0000);
    step();
    put(0, 12'd5, 16'h0000);
    step();
    put(0, 12'd5, 16'h0001);
    step();
    expect_rd(1, 12'd5, 16'h0000, "R11_holder");
    put(1, 12'd5, 16'h0001);
    step();
    expect_rd(0, 12'd5, 16'hFFFF, "R11_withdrawn");
    expect_rd(1, 12'd5, 16'hFFFF, "R11_withdrawn");
    put(0, 12'd6, 16'h0001);  // release of free token: no effect
    step();
    expect_rd(0, 12'd6, 16'hFFFF, "R11_freerel");
    put(1, 12'd6, 16'h0000);
    step();
    expect_rd(1, 12'd6, 16'h0000, "R11_freerel");
    put(1, 12'd6, 16'h0001);
    step();

    // R7: simultaneous request, left wins, right pending
    for (int i = 0; i < 8; i++) begin
      put(0, 12'(i), 16'h0000);
      put(1, 12'(i), 16'h0000);
      step();
      expect_rd(0, 12'(i), 16'h0000, "R7_left");
      expect_rd(1, 12'(i), 16'hFFFF, "R7_right");
      put(0, 12'(i), 16'h0001);
      step();
      expect_rd(1, 12'(i), 16'h0000, "R7_pend");
      put(1, 12'(i), 16'h0001);
      step();
      expect_rd(0, 12'(i), 16'hFFFF, "R7_end");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule